// File: doc/BRIEF.md
# Prioritized Background Window Merger

This block sits at the end of a text-overlay pixel pipeline. For every dot it takes the character cell being drawn (row and column index), an active-display flag, the glyph foreground bit and the per-row colour palette. It checks these against three programmable rectangular background windows and produces the final RGB dot colour. It also produces a halftone signal that lets external video amplifiers dim the picture behind a window, and a fast-blank signal with its own output enable that tells the video switch when the overlay owns the screen.

Windows are given by inclusive character-cell bounds. Window 0 has the highest priority and window 2 the lowest. The winning window decides the background colour. It also decides whether a lit glyph dot picks its colour from the primary or the alternate colour pair of the row. Timing generation, glyph fetch and register loading are done elsewhere. All outputs come from registers one dot clock after their inputs.

Top module: `osd_window_merge`

## Requirements
- R1: Every output is registered: a change on the inputs shows at the outputs after exactly one rising clock edge. While `rst_n` is low, all outputs are 0.
- R2: Window i covers a dot when `activeDisp` is 1 and `rowStart_i <= rowIdx <= rowEnd_i` and `colStart_i <= colIdx <= colEnd_i`. The bounds are inclusive, so start equal to end covers exactly one cell. Window i uses slice i of each packed window vector.
- R3: A window whose `winEnable` bit is 0 covers nothing.
- R4: A window whose row start is greater than its row end, or whose column start is greater than its column end, covers nothing.
- R5: Where several windows cover a dot, the lowest-numbered window wins. Its RGB value (`{R,G,B}`) is the window colour.
- R6: A lit glyph dot (`charDot`=1 with `activeDisp`=1) takes palette slot k = {alt, `charColorSel`}. Here alt is the `winAlt` bit of the winning window, or 0 when no window covers the dot. Slot k is `rowColors[3k+2:3k]`, so slots 0 and 1 are the primary pair and slots 2 and 3 are the alternate pair.
- R7: `rgbOut` is the bitwise OR of the glyph colour and the window colour. The window colour is forced to 0 on lit glyph dots. An unlit or inactive dot gives a glyph colour of 0.
- R8: `halftone` is 1 exactly where a window covers the dot and no glyph dot is lit.
- R9: With `fbCharOnly`=0, `fastBlank` is 1 on lit glyph dots and on covered dots. With `fbCharOnly`=1, it is 1 only on lit glyph dots. `fastBlankOe` equals `fastBlank`, so the pin floats when there is nothing to show.
- R10: While `osdEnable` is 0, `rgbOe`, `fastBlankOe`, `fastBlank`, `halftone` and `rgbOut` are all 0. While it is 1, `rgbOe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | dot clock |
| rst_n | input | 1 | asynchronous active-low reset |
| osdEnable | input | 1 | overlay on; when 0 the outputs float |
| fbCharOnly | input | 1 | fast-blank shows glyph dots only |
| activeDisp | input | 1 | current dot lies in the character field |
| rowIdx | input | 4 | character row of the current dot |
| colIdx | input | 5 | character column of the current dot |
| charDot | input | 1 | glyph foreground bit |
| charColorSel | input | 1 | colour select bit from the display cell |
| rowColors | input | 12 | four 3-bit palette slots of the row |
| winEnable | input | 3 | per-window enable |
| winAlt | input | 3 | per-window alternate-pair select |
| winRowStart | input | 12 | per-window first row |
| winRowEnd | input | 12 | per-window last row |
| winColStart | input | 15 | per-window first column |
| winColEnd | input | 15 | per-window last column |
| winRgb | input | 9 | per-window background colour |
| rgbOut | output | 3 | final {R,G,B} |
| rgbOe | output | 1 | RGB drive enable |
| halftone | output | 1 | window background without glyph dot |
| fastBlank | output | 1 | overlay owns this dot |
| fastBlankOe | output | 1 | fast-blank drive enable |

## Verification
The main function is tried with one fixed set of three windows. They overlap pairwise and sit next to uncovered cells. The dots probed fall in single-window areas, in overlap areas, on inclusive corners and just outside the edges, so the cases separate a priority error from a bound error. Each such cell is probed with the glyph dot off and on, and with both colour-select values. This shows the primary pair against the alternate pair, and shows that the pair follows the winning window rather than any covering one. Both fast-blank settings and inactive dots are mixed in. Directed cases then disable a window, invert its bounds, shrink it to one cell and switch the overlay off.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;
  // strobes passed from the hit/priority control to the colour datapath
  typedef struct packed {
    logic showWin;   // some window covers the current dot
    logic charLit;   // glyph dot lit inside the active field
    logic altPair;   // winning window asks for the alternate colour pair
  } winStrobes_t;
endpackage

// File: rtl/osd_win_ctl.sv
module osd_win_ctl
  import osd_win_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     activeDisp,
  input  logic [ROW_W-1:0]         rowIdx,
  input  logic [COL_W-1:0]         colIdx,
  input  logic                     charDot,
  input  logic [NUM_WIN-1:0]       winEnable,
  input  logic [NUM_WIN-1:0]       winAlt,
  input  logic [NUM_WIN*ROW_W-1:0] winRowStart,
  input  logic [NUM_WIN*ROW_W-1:0] winRowEnd,
  input  logic [NUM_WIN*COL_W-1:0] winColStart,
  input  logic [NUM_WIN*COL_W-1:0] winColEnd,
  output logic [NUM_WIN-1:0]       winSel,
  output winStrobes_t              strobes
);
  logic [NUM_WIN-1:0] winHit;

  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    logic [ROW_W-1:0] rs, re;
    logic [COL_W-1:0] cs, ce;
    logic rowIn, colIn, wellFormed;
    assign rs = winRowStart[i*ROW_W +: ROW_W];
    assign re = winRowEnd[i*ROW_W +: ROW_W];
    assign cs = winColStart[i*COL_W +: COL_W];
    assign ce = winColEnd[i*COL_W +: COL_W];
    assign wellFormed = (rs <= re) && (cs <= ce);
    assign rowIn = (rowIdx >= rs) && (rowIdx <= re);
    assign colIn = (colIdx >= cs) && (colIdx <= ce);
    assign winHit[i] = winEnable[i] && activeDisp && wellFormed && rowIn && colIn;

    // R3: a disabled window never wins
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !winEnable[i] |-> !winSel[i]);
    // R4: inverted bounds never win
    assert_inverted_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rs > re) || (cs > ce)) |-> !winSel[i]);
  end

  // fixed priority: lowest index wins
  always_comb begin
    winSel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winHit[i]) begin
        winSel = '0;
        winSel[i] = 1'b1;
      end
    end
  end

  always_comb begin
    strobes.showWin = |winHit;
    strobes.charLit = activeDisp && charDot;
    strobes.altPair = |(winSel & winAlt);
  end

  // R5: at most one window is chosen, and one is chosen whenever any covers
  assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winSel) && (strobes.showWin == (winSel != '0)));
endmodule

// File: rtl/osd_win_dp.sv
module osd_win_dp
  import osd_win_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int COLOR_W = 3,
  parameter int PAL_N   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osdEnable,
  input  logic                       fbCharOnly,
  input  logic                       charColorSel,
  input  logic [PAL_N*COLOR_W-1:0]   rowColors,
  input  logic [NUM_WIN*COLOR_W-1:0] winRgb,
  input  logic [NUM_WIN-1:0]         winSel,
  input  winStrobes_t                strobes,
  output logic [COLOR_W-1:0]         rgbOut,
  output logic                       rgbOe,
  output logic                       halftone,
  output logic                       fastBlank,
  output logic                       fastBlankOe
);
  localparam int PAL_IDX_W = $clog2(PAL_N);

  logic [COLOR_W-1:0]   winColor, charColor, winPaintColor;
  logic [PAL_IDX_W-1:0] palIdx;
  logic                 winPaint, fbNext;

  always_comb begin
    winColor = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (winSel[i]) winColor = winColor | winRgb[i*COLOR_W +: COLOR_W];
  end

  assign palIdx        = {strobes.altPair, charColorSel};
  assign charColor     = strobes.charLit ? rowColors[palIdx*COLOR_W +: COLOR_W] : '0;
  assign winPaint      = strobes.showWin && !strobes.charLit;
  assign winPaintColor = winPaint ? winColor : '0;
  assign fbNext        = strobes.charLit || (!fbCharOnly && strobes.showWin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgbOut      <= '0;
      rgbOe       <= 1'b0;
      halftone    <= 1'b0;
      fastBlank   <= 1'b0;
      fastBlankOe <= 1'b0;
    end else if (!osdEnable) begin
      rgbOut      <= '0;
      rgbOe       <= 1'b0;
      halftone    <= 1'b0;
      fastBlank   <= 1'b0;
      fastBlankOe <= 1'b0;
    end else begin
      rgbOut      <= charColor | winPaintColor;
      rgbOe       <= 1'b1;
      halftone    <= winPaint;
      fastBlank   <= fbNext;
      fastBlankOe <= fbNext;
    end
  end

  // R10: overlay off floats every driver on the next dot
  assert_off_floats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(osdEnable) |-> (!rgbOe && !fastBlankOe && !halftone));
  // R8: a lit glyph dot never shows halftone
  assert_no_tone_on_dot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.charLit) |-> !halftone);
  // R9: glyph-only fast-blank follows the lit dot alone
  assert_fb_char_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(osdEnable && fbCharOnly) |-> (fastBlank == $past(strobes.charLit)));
  // R7: window background only appears while RGB is driven
  assert_tone_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halftone |-> rgbOe);
endmodule

// File: rtl/osd_window_merge.sv
module osd_window_merge
  import osd_win_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 5,
  parameter int COLOR_W = 3,
  parameter int PAL_N   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osdEnable,
  input  logic                       fbCharOnly,
  input  logic                       activeDisp,
  input  logic [ROW_W-1:0]           rowIdx,
  input  logic [COL_W-1:0]           colIdx,
  input  logic                       charDot,
  input  logic                       charColorSel,
  input  logic [PAL_N*COLOR_W-1:0]   rowColors,
  input  logic [NUM_WIN-1:0]         winEnable,
  input  logic [NUM_WIN-1:0]         winAlt,
  input  logic [NUM_WIN*ROW_W-1:0]   winRowStart,
  input  logic [NUM_WIN*ROW_W-1:0]   winRowEnd,
  input  logic [NUM_WIN*COL_W-1:0]   winColStart,
  input  logic [NUM_WIN*COL_W-1:0]   winColEnd,
  input  logic [NUM_WIN*COLOR_W-1:0] winRgb,
  output logic [COLOR_W-1:0]         rgbOut,
  output logic                       rgbOe,
  output logic                       halftone,
  output logic                       fastBlank,
  output logic                       fastBlankOe
);
  logic [NUM_WIN-1:0] winSel;
  winStrobes_t        strobes;

  osd_win_ctl #(.NUM_WIN(NUM_WIN), .ROW_W(ROW_W), .COL_W(COL_W)) uCtl (
    .clk(clk), .rst_n(rst_n), .activeDisp(activeDisp), .rowIdx(rowIdx),
    .colIdx(colIdx), .charDot(charDot), .winEnable(winEnable), .winAlt(winAlt),
    .winRowStart(winRowStart), .winRowEnd(winRowEnd),
    .winColStart(winColStart), .winColEnd(winColEnd),
    .winSel(winSel), .strobes(strobes)
  );

  osd_win_dp #(.NUM_WIN(NUM_WIN), .COLOR_W(COLOR_W), .PAL_N(PAL_N)) uDp (
    .clk(clk), .rst_n(rst_n), .osdEnable(osdEnable), .fbCharOnly(fbCharOnly),
    .charColorSel(charColorSel), .rowColors(rowColors), .winRgb(winRgb),
    .winSel(winSel), .strobes(strobes),
    .rgbOut(rgbOut), .rgbOe(rgbOe), .halftone(halftone),
    .fastBlank(fastBlank), .fastBlankOe(fastBlankOe)
  );

  // R1: fast-blank and its enable move together, one register stage apart from inputs
  assert_fb_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fastBlank == fastBlankOe);
endmodule

// File: tb/osd_window_merge_test.sv
`timescale 1ns/1ps
module osd_window_merge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osdEnable = 1'b0, fbCharOnly = 1'b0, activeDisp = 1'b0;
  logic [3:0]  rowIdx = '0;
  logic [4:0]  colIdx = '0;
  logic        charDot = 1'b0, charColorSel = 1'b0;
  logic [11:0] rowColors;
  logic [2:0]  winEnable, winAlt;
  logic [11:0] winRowStart, winRowEnd;
  logic [14:0] winColStart, winColEnd;
  logic [8:0]  winRgb;
  logic [2:0]  rgbOut;
  logic        rgbOe, halftone, fastBlank, fastBlankOe;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  osd_window_merge uut (.*);

  // vector: {row, col, act, dot, sel, fbCharOnly, expRgb, expHalftone, expFb, expFbOe}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {4'd0, 5'd0,  1'b1,1'b0,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0}, // uncovered blank
    {4'd0, 5'd0,  1'b1,1'b1,1'b0,1'b0, 3'b111,1'b0,1'b1,1'b1}, // slot0
    {4'd0, 5'd0,  1'b1,1'b1,1'b1,1'b0, 3'b011,1'b0,1'b1,1'b1}, // slot1
    {4'd2, 5'd5,  1'b1,1'b0,1'b0,1'b0, 3'b001,1'b1,1'b1,1'b1}, // win0 corner
    {4'd2, 5'd5,  1'b1,1'b0,1'b0,1'b1, 3'b001,1'b1,1'b0,1'b0}, // glyph-only fb
    {4'd3, 5'd8,  1'b1,1'b0,1'b0,1'b0, 3'b001,1'b1,1'b1,1'b1}, // overlap -> win0
    {4'd5, 5'd8,  1'b1,1'b0,1'b0,1'b0, 3'b010,1'b1,1'b1,1'b1}, // win1 only
    {4'd3, 5'd10, 1'b1,1'b0,1'b0,1'b0, 3'b010,1'b1,1'b1,1'b1}, // win1 only
    {4'd2, 5'd5,  1'b1,1'b1,1'b0,1'b0, 3'b101,1'b0,1'b1,1'b1}, // alt slot2
    {4'd2, 5'd5,  1'b1,1'b1,1'b1,1'b0, 3'b110,1'b0,1'b1,1'b1}, // alt slot3
    {4'd5, 5'd8,  1'b1,1'b1,1'b1,1'b0, 3'b011,1'b0,1'b1,1'b1}, // win1 primary
    {4'd3, 5'd8,  1'b1,1'b1,1'b0,1'b0, 3'b101,1'b0,1'b1,1'b1}, // pair from winner
    {4'd4, 5'd9,  1'b1,1'b0,1'b0,1'b0, 3'b001,1'b1,1'b1,1'b1}, // far corner
    {4'd1, 5'd5,  1'b1,1'b0,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0}, // row above
    {4'd7, 5'd3,  1'b1,1'b0,1'b0,1'b0, 3'b110,1'b1,1'b1,1'b1}, // win2 edge
    {4'd7, 5'd4,  1'b1,1'b0,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0}, // past win2
    {4'd2, 5'd5,  1'b0,1'b1,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0}, // inactive
    {4'd8, 5'd2,  1'b1,1'b1,1'b0,1'b1, 3'b101,1'b0,1'b1,1'b1}  // win2 alt
  };

  task automatic check(input string tag, input logic [2:0] eRgb, input logic eOe,
                       input logic eHt, input logic eFb, input logic eFbOe);
    checks++;
    if (rgbOut !== eRgb || rgbOe !== eOe || halftone !== eHt ||
        fastBlank !== eFb || fastBlankOe !== eFbOe) begin
      bad++;
      $display("FAIL %s: got rgb=%b oe=%b ht=%b fb=%b fbOe=%b exp rgb=%b oe=%b ht=%b fb=%b fbOe=%b",
               tag, rgbOut, rgbOe, halftone, fastBlank, fastBlankOe,
               eRgb, eOe, eHt, eFb, eFbOe);
    end
  endtask

  // drive at negedge, one rising edge passes, sample at the next negedge
  task automatic step(input logic [3:0] r, input logic [4:0] c, input logic a,
                      input logic d, input logic s, input logic f);
    rowIdx = r; colIdx = c; activeDisp = a; charDot = d; charColorSel = s; fbCharOnly = f;
    @(negedge clk);
  endtask

  task automatic setWindows();
    winRowStart = {4'd7, 4'd3, 4'd2};
    winRowEnd   = {4'd9, 4'd6, 4'd4};
    winColStart = {5'd0, 5'd8, 5'd5};
    winColEnd   = {5'd3, 5'd12, 5'd9};
    winEnable   = 3'b111;
    winAlt      = 3'b101;
    winRgb      = {3'b110, 3'b010, 3'b001};
  endtask

  initial begin
    rowColors = {3'b110, 3'b101, 3'b011, 3'b111};
    setWindows();
    activeDisp = 1'b1; charDot = 1'b1; osdEnable = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds all outputs low even with stimulus present
    check("R1 reset", 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: latency — first sample one edge after a change
    rowIdx = 4'd2; colIdx = 5'd5; charDot = 1'b0; fbCharOnly = 1'b0;
    @(posedge clk); #1;
    rowIdx = 4'd0; colIdx = 5'd0;
    @(negedge clk);
    check("R1 latency", 3'b001, 1'b1, 1'b1, 1'b1, 1'b1);

    // table: R2 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      step(v[18:15], v[14:10], v[9], v[8], v[7], v[6]);
      check($sformatf("R2 R5 R6 R7 R8 R9 vector %0d", i), v[5:3], 1'b1, v[2], v[1], v[0]);
    end

    // R3: disabling window 0 at its own cell exposes nothing beneath
    winEnable = 3'b110;
    step(4'd2, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 disabled", 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    // R3/R5: overlap cell now falls to window 1
    step(4'd3, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 R5 fallthrough", 3'b010, 1'b1, 1'b1, 1'b1, 1'b1);
    winEnable = 3'b111;

    // R4: inverted row bounds on window 0
    winRowStart[3:0] = 4'd5; winRowEnd[3:0] = 4'd2;
    step(4'd3, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 row inverted", 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    setWindows();
    // R4: inverted column bounds on window 0
    winColStart[4:0] = 5'd9; winColEnd[4:0] = 5'd5;
    step(4'd3, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 col inverted", 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    setWindows();

    // R2: single-cell window 1 at row 11 col 20
    winRowStart[7:4] = 4'd11; winRowEnd[7:4] = 4'd11;
    winColStart[9:5] = 5'd20; winColEnd[9:5] = 5'd20;
    step(4'd11, 5'd20, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 single cell", 3'b010, 1'b1, 1'b1, 1'b1, 1'b1);
    step(4'd11, 5'd21, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 single cell neighbour", 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    setWindows();

    // R10: overlay off floats everything, even on a lit dot in a window
    osdEnable = 1'b0;
    step(4'd2, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R10 off", 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    osdEnable = 1'b1;
    step(4'd2, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R10 on again", 3'b101, 1'b1, 1'b0, 1'b1, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule